// File: doc/BRIEF.md
# Core Low-Power State Controller

This block keeps track of which operating state a processor core is in: Execution, WAIT, STOP or Debug. Software asks to sleep with single-cycle request pulses. Each low-power state has its own set of wake events. A debug handling mode is captured at the moment the core goes to sleep. That captured mode decides whether a debug event wakes the core into a debug exception or parks it in Debug state.

From the current state the block drives two clock enables: one for the core and one for the peripherals. It also emits a one-cycle debug-exception pulse, and it keeps a code for the wake source that brought the core out of its last sleep. The clock gating cells, the JTAG TAP and interrupt prioritisation are outside this block. All inputs are synchronous and active-high. Reset is synchronous.

Top module: `core_pwr_state_ctrl`

## Requirements
- R1: While reset is high, and after it is released, the state is Execution (`state` = 0) and `wake_cause` = 0. `dbg_exc_pulse` is 0 and both clock enables are 1.
- R2: In Execution, a `sleep_wait_req` pulse moves the state to WAIT (1) on the next clock, and a `sleep_stop_req` pulse moves it to STOP (2). If both arrive together, STOP wins. Requests made in any other state are ignored.
- R3: `core_clk_en` is 1 in Execution and Debug and 0 in WAIT and STOP. `periph_clk_en` is 0 only in STOP.
- R4: In WAIT, an interrupt line that is both requested and enabled (`irq_req[i] & irq_en[i]`) returns the core to Execution with `wake_cause` = 3. A requested line that is not enabled has no effect.
- R5: In WAIT, `nmi_req` returns the core to Execution with `wake_cause` = 2.
- R6: In STOP, `wake_pin` returns the core to Execution with `wake_cause` = 4. Interrupt requests and `nmi_req` are ignored in STOP, and `wake_pin` is ignored in WAIT.
- R7: A debug event (`jtag_dbg_req` or `ext_event`) in WAIT or STOP sets `wake_cause` = 1. If the captured mode is 1, the core goes to Execution and `dbg_exc_pulse` is high for exactly one cycle. If the captured mode is 0, the core goes to Debug (3) and no pulse is raised.
- R8: `dbg_exc_mode` is captured on the clock that enters WAIT or STOP. Changing it while the core sleeps has no effect on how the wake is handled.
- R9: Debug state is left for Execution only when `dbg_exit_cmd` is high. All other inputs are ignored in Debug.
- R10: When wake events coincide, the reported cause follows the priority debug event, then NMI, then enabled interrupt, then wake pin.
- R11: `wake_cause` keeps its value until the next sleep entry, and that entry clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_wait_req | input | 1 | Single-cycle request to enter WAIT |
| sleep_stop_req | input | 1 | Single-cycle request to enter STOP |
| wake_pin | input | 1 | Dedicated wake signal, used in STOP |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| nmi_req | input | 1 | Non-maskable interrupt request |
| jtag_dbg_req | input | 1 | Debug request from the JTAG side |
| ext_event | input | 1 | External debug event input |
| dbg_exit_cmd | input | 1 | Debug command exit bit written to one |
| dbg_exc_mode | input | 1 | 1: debug events become exceptions; 0: enter Debug state |
| state | output | 2 | 0 Execution, 1 WAIT, 2 STOP, 3 Debug |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| dbg_exc_pulse | output | 1 | One-cycle debug exception request |
| wake_cause | output | 3 | 0 none, 1 debug, 2 NMI, 3 interrupt, 4 wake pin |

## Verification
The bench changes the debug mode input while the core is asleep. A design that read the live bit instead of the captured one would then choose the wrong destination. It drives NMI, enabled interrupts and requests into STOP and Debug: a design that used a single wake set for every state would wake up there. It also sends a masked interrupt and a wake pin into WAIT. Coincident wake sources are applied together to expose any wrong priority order, and the bench checks that the exception pulse lasts a single cycle and that the cause is still held several cycles after wake.

// File: rtl/cpsc_pkg.sv
package cpsc_pkg;
   typedef enum logic [1:0] {
      ST_EXEC  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_STOP  = 2'd2,
      ST_DEBUG = 2'd3
   } core_state_t;

   localparam int CAUSE_W = 3;
   localparam logic [CAUSE_W-1:0] CAUSE_NONE = 3'd0;
   localparam logic [CAUSE_W-1:0] CAUSE_DBG  = 3'd1;
   localparam logic [CAUSE_W-1:0] CAUSE_NMI  = 3'd2;
   localparam logic [CAUSE_W-1:0] CAUSE_IRQ  = 3'd3;
   localparam logic [CAUSE_W-1:0] CAUSE_PIN  = 3'd4;
endpackage

// File: rtl/cpsc_wake_arb.sv
module cpsc_wake_arb
   import cpsc_pkg::*;
#(
   parameter int N_IRQ = 8
) (
   input  core_state_t            cur_st,
   input  logic [N_IRQ-1:0]       irq_req,
   input  logic [N_IRQ-1:0]       irq_en,
   input  logic                   nmi_req,
   input  logic                   jtag_dbg_req,
   input  logic                   ext_event,
   input  logic                   wake_pin,
   output logic                   wake_hit,
   output logic [CAUSE_W-1:0]     wake_code
);
   if (N_IRQ < 1) begin : g_bad_irq
      $error("cpsc_wake_arb: N_IRQ must be at least 1");
   end

   logic [N_IRQ-1:0] live_irq;
   for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
      assign live_irq[i] = irq_req[i] & irq_en[i];
   end

   logic in_wait, in_stop;
   logic ev_dbg, ev_nmi, ev_irq, ev_pin;

   assign in_wait = (cur_st == ST_WAIT);
   assign in_stop = (cur_st == ST_STOP);
   assign ev_dbg  = (in_wait | in_stop) & (jtag_dbg_req | ext_event);
   assign ev_nmi  = in_wait & nmi_req;
   assign ev_irq  = in_wait & (|live_irq);
   assign ev_pin  = in_stop & wake_pin;

   always_comb begin
      wake_hit  = 1'b1;
      wake_code = CAUSE_NONE;
      if (ev_dbg)      wake_code = CAUSE_DBG;
      else if (ev_nmi) wake_code = CAUSE_NMI;
      else if (ev_irq) wake_code = CAUSE_IRQ;
      else if (ev_pin) wake_code = CAUSE_PIN;
      else             wake_hit  = 1'b0;
   end
endmodule

// File: rtl/cpsc_fsm.sv
module cpsc_fsm
   import cpsc_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic               sleep_wait_req,
   input  logic               sleep_stop_req,
   input  logic               dbg_exit_cmd,
   input  logic               dbg_exc_mode,
   input  logic               wake_hit,
   input  logic [CAUSE_W-1:0] wake_code,
   output core_state_t        st_q,
   output logic [CAUSE_W-1:0] cause_q,
   output logic               exc_pulse_q
);
   logic mode_sh;
   logic entering;
   logic waking;

   assign entering = (st_q == ST_EXEC) & (sleep_wait_req | sleep_stop_req);
   assign waking   = ((st_q == ST_WAIT) | (st_q == ST_STOP)) & wake_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q        <= ST_EXEC;
         mode_sh     <= 1'b0;
         cause_q     <= CAUSE_NONE;
         exc_pulse_q <= 1'b0;
      end else begin
         exc_pulse_q <= 1'b0;
         unique case (st_q)
            ST_EXEC: begin
               if (entering) begin
                  st_q    <= sleep_stop_req ? ST_STOP : ST_WAIT;
                  mode_sh <= dbg_exc_mode;
                  cause_q <= CAUSE_NONE;
               end
            end
            ST_WAIT, ST_STOP: begin
               if (wake_hit) begin
                  cause_q <= wake_code;
                  if (wake_code == CAUSE_DBG && !mode_sh) begin
                     st_q <= ST_DEBUG;
                  end else begin
                     st_q <= ST_EXEC;
                     exc_pulse_q <= (wake_code == CAUSE_DBG);
                  end
               end
            end
            ST_DEBUG: begin
               if (dbg_exit_cmd) st_q <= ST_EXEC;
            end
            default: st_q <= ST_EXEC;
         endcase
      end
   end

   // R11
   cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!entering && !waking) |=> $stable(cause_q));
   // R2
   stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_EXEC && sleep_stop_req) |=> (st_q == ST_STOP));
   // R9
   debug_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_DEBUG && !dbg_exit_cmd) |=> (st_q == ST_DEBUG));
   // R7
   exc_single_chk: assert property (@(posedge clk) disable iff (rst)
      exc_pulse_q |=> !exc_pulse_q);
endmodule

// File: rtl/cpsc_clk_ctrl.sv
module cpsc_clk_ctrl
   import cpsc_pkg::*;
(
   input  core_state_t cur_st,
   output logic        core_clk_en,
   output logic        periph_clk_en
);
   always_comb begin
      unique case (cur_st)
         ST_WAIT: begin core_clk_en = 1'b0; periph_clk_en = 1'b1; end
         ST_STOP: begin core_clk_en = 1'b0; periph_clk_en = 1'b0; end
         default: begin core_clk_en = 1'b1; periph_clk_en = 1'b1; end
      endcase
   end
endmodule

// File: rtl/core_pwr_state_ctrl.sv
module core_pwr_state_ctrl
   import cpsc_pkg::*;
#(
   parameter int N_IRQ = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sleep_wait_req,
   input  logic               sleep_stop_req,
   input  logic               wake_pin,
   input  logic [N_IRQ-1:0]   irq_req,
   input  logic [N_IRQ-1:0]   irq_en,
   input  logic               nmi_req,
   input  logic               jtag_dbg_req,
   input  logic               ext_event,
   input  logic               dbg_exit_cmd,
   input  logic               dbg_exc_mode,
   output logic [1:0]         state,
   output logic               core_clk_en,
   output logic               periph_clk_en,
   output logic               dbg_exc_pulse,
   output logic [CAUSE_W-1:0] wake_cause
);
   core_state_t        st;
   logic               hit;
   logic [CAUSE_W-1:0] code;

   cpsc_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
      .cur_st(st), .irq_req(irq_req), .irq_en(irq_en), .nmi_req(nmi_req),
      .jtag_dbg_req(jtag_dbg_req), .ext_event(ext_event), .wake_pin(wake_pin),
      .wake_hit(hit), .wake_code(code)
   );

   cpsc_fsm u_fsm (
      .clk(clk), .rst(rst), .sleep_wait_req(sleep_wait_req),
      .sleep_stop_req(sleep_stop_req), .dbg_exit_cmd(dbg_exit_cmd),
      .dbg_exc_mode(dbg_exc_mode), .wake_hit(hit), .wake_code(code),
      .st_q(st), .cause_q(wake_cause), .exc_pulse_q(dbg_exc_pulse)
   );

   cpsc_clk_ctrl u_clk (
      .cur_st(st), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en)
   );

   assign state = st;

   // R6
   stop_ignores_irq_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_STOP && !wake_pin && !jtag_dbg_req && !ext_event) |=> (st == ST_STOP));
   // R3
   clk_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!periph_clk_en |-> !core_clk_en));
   // R7
   pulse_exec_chk: assert property (@(posedge clk) disable iff (rst)
      dbg_exc_pulse |-> (st == ST_EXEC && wake_cause == CAUSE_DBG));
endmodule

// File: tb/core_pwr_state_ctrl_tb.sv
module core_pwr_state_ctrl_tb;
   localparam int NI = 8;
   logic clk = 0, rst = 1;
   logic wreq = 0, sreq = 0, pin = 0, nmi = 0, jtag = 0, ext = 0, dexit = 0, mode = 0;
   logic [NI-1:0] irq = '0, en = '0;
   logic [1:0] state;
   logic cclk, pclk, pulse;
   logic [2:0] cause;
   int errors = 0, checks = 0;

   always #10 clk = ~clk;

   core_pwr_state_ctrl #(.N_IRQ(NI)) u_dut (
      .clk(clk), .rst(rst), .sleep_wait_req(wreq), .sleep_stop_req(sreq),
      .wake_pin(pin), .irq_req(irq), .irq_en(en), .nmi_req(nmi),
      .jtag_dbg_req(jtag), .ext_event(ext), .dbg_exit_cmd(dexit),
      .dbg_exc_mode(mode), .state(state), .core_clk_en(cclk),
      .periph_clk_en(pclk), .dbg_exc_pulse(pulse), .wake_cause(cause)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_in();
      wreq = 0; sreq = 0; pin = 0; nmi = 0; jtag = 0; ext = 0; dexit = 0;
      irq = '0; en = '0;
   endtask

   task automatic enter(input bit stop, input bit m);
      mode = m;
      if (stop) sreq = 1; else wreq = 1;
      tick();
      clear_in();
   endtask

   task automatic t_reset();
      rst = 1; tick(); tick();
      chk("R1 state in reset", state, 0);
      chk("R1 cause in reset", cause, 0);
      rst = 0; tick();
      chk("R1 state after reset", state, 0);
      chk("R1 pulse", pulse, 0);
      chk("R3 exec core clk", cclk, 1);
      chk("R3 exec periph clk", pclk, 1);
   endtask

   task automatic t_wait_irq();
      enter(0, 1);
      chk("R2 wait entry", state, 1);
      chk("R3 wait core clk", cclk, 0);
      chk("R3 wait periph clk", pclk, 1);
      chk("R11 cleared on entry", cause, 0);
      irq = 8'h10; en = 8'h0F; tick(); clear_in();
      chk("R4 masked irq ignored", state, 1);
      pin = 1; tick(); clear_in();
      chk("R6 pin ignored in wait", state, 1);
      sreq = 1; tick(); clear_in();
      chk("R2 request ignored in wait", state, 1);
      irq = 8'h18; en = 8'h08; tick(); clear_in();
      chk("R4 irq wake state", state, 0);
      chk("R4 irq cause", cause, 3);
      chk("R4 no pulse", pulse, 0);
   endtask

   task automatic t_wait_nmi();
      enter(0, 1);
      nmi = 1; tick(); clear_in();
      chk("R5 nmi wake state", state, 0);
      chk("R5 nmi cause", cause, 2);
   endtask

   task automatic t_stop_pin();
      enter(1, 1);
      chk("R2 stop entry", state, 2);
      chk("R3 stop core clk", cclk, 0);
      chk("R3 stop periph clk", pclk, 0);
      nmi = 1; irq = 8'hFF; en = 8'hFF; tick(); clear_in();
      chk("R6 irq/nmi ignored in stop", state, 2);
      wreq = 1; tick(); clear_in();
      chk("R2 request ignored in stop", state, 2);
      pin = 1; tick(); clear_in();
      chk("R6 pin wake state", state, 0);
      chk("R6 pin cause", cause, 4);
      tick(); tick(); tick();
      chk("R11 cause held", cause, 4);
      enter(0, 1);
      chk("R11 cause cleared at entry", cause, 0);
      nmi = 1; tick(); clear_in();
   endtask

   task automatic t_dbg_exc();
      enter(1, 1);
      mode = 0;
      jtag = 1; tick(); clear_in();
      chk("R8 latched exception mode state", state, 0);
      chk("R7 pulse raised", pulse, 1);
      chk("R7 debug cause", cause, 1);
      tick();
      chk("R7 pulse one cycle", pulse, 0);
   endtask

   task automatic t_dbg_state();
      enter(0, 0);
      mode = 1;
      ext = 1; tick(); clear_in();
      chk("R8 latched debug mode state", state, 3);
      chk("R7 no pulse into debug", pulse, 0);
      chk("R7 debug cause", cause, 1);
      chk("R3 debug core clk", cclk, 1);
      wreq = 1; nmi = 1; pin = 1; jtag = 1; irq = 8'hFF; en = 8'hFF; tick(); clear_in();
      chk("R9 debug ignores others", state, 3);
      dexit = 1; tick(); clear_in();
      chk("R9 exit command", state, 0);
   endtask

   task automatic t_priority();
      enter(0, 1);
      nmi = 1; irq = 8'h01; en = 8'h01; tick(); clear_in();
      chk("R10 nmi over irq", cause, 2);
      enter(0, 1);
      jtag = 1; nmi = 1; irq = 8'h01; en = 8'h01; tick(); clear_in();
      chk("R10 debug over nmi", cause, 1);
      enter(1, 1);
      ext = 1; pin = 1; tick(); clear_in();
      chk("R10 debug over pin", cause, 1);
      wreq = 1; sreq = 1; tick(); clear_in();
      chk("R2 stop wins over wait", state, 2);
      pin = 1; tick(); clear_in();
   endtask

   initial begin
      tick();
      t_reset();
      t_wait_irq();
      t_wait_nmi();
      t_stop_pin();
      t_dbg_exc();
      t_dbg_state();
      t_priority();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule